// File: doc/BRIEF.md
# Processor Supervisor with Watchdog and Reset Stretcher

This block drives a processor reset line from two sources. The first is a synchronous digital flag that reports that the supply has fallen below its threshold. While the flag is up, reset is held. Once the flag drops, reset is held for a programmable number of clocks and then released. The second source is a watchdog. After reset releases, the processor must produce an edge on the kick input, either rising or falling, before a programmable tick count runs out. If it does not, the block issues a reset pulse with the same stretched length. This repeats until the processor starts servicing the watchdog.

A mode input multiplies the base timeout by 500. In the extended mode, software can declare the kick input undriven. The block then services itself at about 94% of the timeout, so the watchdog never fires. A separate enable removes the watchdog altogether and leaves the supply path untouched. Reset is presented as a complementary pair. A one-clock status pulse marks each reset that the watchdog started.

Top module: `svr_supervisor`

## Requirements
- R1: While `supplyLow` is 1, `resetOutN` is 0 in the same cycle, without waiting for a clock edge, and stays 0 for as long as the flag stays up.
- R2: Take the first rising edge at which `supplyLow` is sampled 0 after being 1 as edge 1. Reset stays asserted through edge `holdTicks`-1 and releases at edge `holdTicks` (`holdTicks` >= 1).
- R3: Take the edge at which reset releases as edge 0. With no kick, the watchdog re-asserts reset at edge T, so reset is released for exactly T cycles. T is `baseTicks` in normal mode. The reset then lasts `holdTicks` cycles, and the cycle repeats.
- R4: The kick input passes through two synchronizing flops and an edge detector. A rising or a falling change that is applied just after edge p restarts the watchdog count at edge p+3. The next expiry then comes T cycles later.
- R5: A change of `modeExt` in either direction restarts the watchdog count with the same three-edge latency as a kick. From then on the count uses the new mode's timeout.
- R6: With `modeExt` = 1, T = 500 × `baseTicks`.
- R7: With `modeExt` = 1 and `kickDriven` = 0, the block kicks itself when the count reaches L − floor(L/16) − 1, where L is the extended timeout. The watchdog never expires.
- R8: With `modeExt` = 0, `kickDriven` has no effect, and the watchdog expires after T = `baseTicks` as in R3.
- R9: With `wdEnable` = 0, the watchdog never asserts reset. The supply-driven reset and its hold time behave as in R1 and R2.
- R10: `resetOut` is always the bitwise inverse of `resetOutN`.
- R11: During the block's own reset (`rstN` = 0), `resetOutN` = 0 and `wdFirePulse` = 0. After `rstN` rises, reset is held as if `supplyLow` had just been seen low, so it releases at the `holdTicks`-th edge.
- R12: `wdFirePulse` is high for exactly one clock, in the first cycle of each reset that a watchdog expiry starts. It never pulses for a supply-caused reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Block power-on reset, active low |
| supplyLow | input | 1 | Supply-below-threshold flag, synchronous to clk |
| kick | input | 1 | Watchdog service input; either edge services |
| kickDriven | input | 1 | 1 when the kick input is actively driven |
| modeExt | input | 1 | 1 selects the extended (×500) timeout |
| wdEnable | input | 1 | 0 disables the watchdog |
| baseTicks | input | CNT_W | Base watchdog timeout in clocks (>= 1) |
| holdTicks | input | CNT_W | Reset hold time in clocks (>= 1) |
| resetOutN | output | 1 | Processor reset, active low |
| resetOut | output | 1 | Processor reset, active high |
| wdFirePulse | output | 1 | One-clock marker of a watchdog-caused reset |

## Verification
The bench sweeps a grid of hold and base counts and measures the lengths of the released and asserted phases. A counter that is off by one in either direction shows up as a run one cycle short or long. Kicks and mode changes are applied at known edges, and the next expiry must come exactly T+3 cycles later. A design that missed one edge polarity or the mode change would expire early. One that left out a synchronizer stage would expire one cycle early. In extended mode with the kick input undriven, the bench waits three times the timeout. A missing self-kick would fire, and a self-kick left active in normal mode would stop the expiry that R8 demands. The supply path is exercised with the watchdog disabled. A pulse leaking onto `wdFirePulse`, or a hold time that counts from the wrong edge, fails there.

// File: rtl/svr_pkg.sv
package svr_pkg;

  // Strobes from the control side to the counters.
  typedef struct packed {
    logic wdClear;    // force watchdog count to zero
    logic holdClear;  // force hold count to zero
    logic holdInc;    // advance hold count
  } svrStrobes_t;

  // Compare results from the counters back to control.
  typedef struct packed {
    logic atLimit;    // watchdog count at timeout - 1
    logic selfHit;    // watchdog count at self-kick point
    logic holdDone;   // hold count at last cycle
  } svrFlags_t;

endpackage

// File: rtl/svr_sync.sv
module svr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[0] <= '0;
        else       chain[0] <= d;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[g] <= '0;
        else       chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/svr_ctrl.sv
module svr_ctrl
  import svr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        supplyLow,
  input  logic        kick,
  input  logic        kickDriven,
  input  logic        modeExt,
  input  logic        wdEnable,
  input  svrFlags_t   flags,
  output svrStrobes_t strobes,
  output logic        modeSync,
  output logic        inReset,
  output logic        firePulse
);

  // bit 0: kick, bit 1: mode, bit 2: kick-driven
  logic [2:0] syncQ;
  logic [1:0] prevQ;
  logic       kickEdge, modeEdge, selfArm, expireNow, inResetNext;

  svr_sync #(.W(3), .STAGES(SYNC_STAGES)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .d    ({kickDriven, modeExt, kick}),
    .q    (syncQ)
  );

  assign modeSync = syncQ[1];
  assign kickEdge = syncQ[0] ^ prevQ[0];
  assign modeEdge = syncQ[1] ^ prevQ[1];
  assign selfArm  = syncQ[1] & ~syncQ[2];

  always_comb begin
    strobes.wdClear   = inReset | supplyLow | ~wdEnable | kickEdge | modeEdge
                      | (selfArm & flags.selfHit);
    strobes.holdClear = supplyLow | ~inReset | flags.holdDone;
    strobes.holdInc   = ~strobes.holdClear;
    expireNow         = ~strobes.wdClear & flags.atLimit;
    if (supplyLow)    inResetNext = 1'b1;
    else if (inReset) inResetNext = ~flags.holdDone;
    else              inResetNext = expireNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ     <= '0;
      inReset   <= 1'b1;
      firePulse <= 1'b0;
    end else begin
      prevQ     <= syncQ[1:0];
      inReset   <= inResetNext;
      firePulse <= expireNow;
    end
  end

  // R12: status is a single-cycle pulse
  assert_fire_single_R12: assert property (@(posedge clk) disable iff (!rstN)
    firePulse |=> !firePulse);

  // R12: a status pulse never follows a cycle with supply low
  assert_fire_not_supply_R12: assert property (@(posedge clk) disable iff (!rstN)
    firePulse |-> $past(!supplyLow));

  // R1: supply low always leaves the reset state held on the next cycle
  assert_supply_holds_R1: assert property (@(posedge clk) disable iff (!rstN)
    supplyLow |=> inReset);

endmodule

// File: rtl/svr_datapath.sv
module svr_datapath
  import svr_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int EXT_MULT   = 500,
  parameter int SELF_SHIFT = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  svrStrobes_t      strobes,
  input  logic             modeSync,
  input  logic [CNT_W-1:0] baseTicks,
  input  logic [CNT_W-1:0] holdTicks,
  output svrFlags_t        flags
);

  localparam int WD_W = CNT_W + $clog2(EXT_MULT);

  logic [WD_W-1:0]  wdCnt, limit, selfPoint;
  logic [CNT_W-1:0] holdCnt, holdLast;

  always_comb begin
    limit     = modeSync ? WD_W'(baseTicks) * WD_W'(EXT_MULT) : WD_W'(baseTicks);
    selfPoint = limit - (limit >> SELF_SHIFT) - WD_W'(1);
    holdLast  = (holdTicks == '0) ? '0 : holdTicks - CNT_W'(1);
    flags.atLimit  = (wdCnt == limit - WD_W'(1));
    flags.selfHit  = (wdCnt == selfPoint);
    flags.holdDone = (holdCnt == holdLast);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                wdCnt <= '0;
    else if (strobes.wdClear) wdCnt <= '0;
    else                      wdCnt <= wdCnt + WD_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  holdCnt <= '0;
    else if (strobes.holdClear) holdCnt <= '0;
    else if (strobes.holdInc)   holdCnt <= holdCnt + CNT_W'(1);
  end

  // R3 / R4: a clear request always leaves the watchdog count at zero
  assert_wd_cleared_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wdClear |=> (wdCnt == '0));

  // R2: the hold count never passes its last value while the setting is steady
  assert_hold_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    $stable(holdTicks) |-> (holdCnt <= holdLast));

  // R3: an uncleared count advances by exactly one
  assert_wd_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wdClear |=> (wdCnt == $past(wdCnt) + WD_W'(1)));

endmodule

// File: rtl/svr_supervisor.sv
module svr_supervisor
  import svr_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int EXT_MULT    = 500,
  parameter int SELF_SHIFT  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             supplyLow,
  input  logic             kick,
  input  logic             kickDriven,
  input  logic             modeExt,
  input  logic             wdEnable,
  input  logic [CNT_W-1:0] baseTicks,
  input  logic [CNT_W-1:0] holdTicks,
  output logic             resetOutN,
  output logic             resetOut,
  output logic             wdFirePulse
);

  svrStrobes_t strobes;
  svrFlags_t   flags;
  logic        modeSync, inReset;

  svr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .supplyLow  (supplyLow),
    .kick       (kick),
    .kickDriven (kickDriven),
    .modeExt    (modeExt),
    .wdEnable   (wdEnable),
    .flags      (flags),
    .strobes    (strobes),
    .modeSync   (modeSync),
    .inReset    (inReset),
    .firePulse  (wdFirePulse)
  );

  svr_datapath #(
    .CNT_W      (CNT_W),
    .EXT_MULT   (EXT_MULT),
    .SELF_SHIFT (SELF_SHIFT)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .modeSync  (modeSync),
    .baseTicks (baseTicks),
    .holdTicks (holdTicks),
    .flags     (flags)
  );

  assign resetOut  = inReset | supplyLow;
  assign resetOutN = ~resetOut;

  // R1: supply low shows on the reset pin without waiting for an edge
  assert_supply_pin_R1: assert property (@(posedge clk) disable iff (!rstN)
    supplyLow |-> !resetOutN);

  // R12: the status pulse only appears while reset is asserted
  assert_fire_in_reset_R12: assert property (@(posedge clk) disable iff (!rstN)
    wdFirePulse |-> resetOut);

  // R9: with the watchdog disabled, no watchdog-caused reset starts
  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!wdEnable && $past(!wdEnable)) |-> !wdFirePulse);

endmodule

// File: tb/svr_supervisor_test.sv
`timescale 1ns/1ps
module svr_supervisor_test;

  localparam int CNT_W = 12;

  logic clk = 1'b0;
  logic rstN, supplyLow, kick, kickDriven, modeExt, wdEnable;
  logic [CNT_W-1:0] baseTicks, holdTicks;
  logic resetOutN, resetOut, wdFirePulse;

  int checks = 0, failures = 0;
  int fireSeen = 0, fireBad = 0, invBad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  svr_supervisor #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .supplyLow(supplyLow), .kick(kick),
    .kickDriven(kickDriven), .modeExt(modeExt), .wdEnable(wdEnable),
    .baseTicks(baseTicks), .holdTicks(holdTicks),
    .resetOutN(resetOutN), .resetOut(resetOut), .wdFirePulse(wdFirePulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Counts samples (one per falling clock edge) until resetOutN leaves lvl.
  task automatic runLen(input logic lvl, input int maxc, output int n);
    n = 0;
    while (resetOutN === lvl && n < maxc) begin
      @(negedge clk);
      n++;
      if (wdFirePulse) fireSeen++;
      if (wdFirePulse && resetOutN) fireBad++;
      if (resetOut !== ~resetOutN) invBad++;
    end
  endtask

  task automatic por(input int h, input int t);
    rstN = 1'b0; supplyLow = 1'b0; kick = 1'b0; kickDriven = 1'b1;
    modeExt = 1'b0; wdEnable = 1'b1;
    holdTicks = CNT_W'(h); baseTicks = CNT_W'(t);
    repeat (3) @(negedge clk);
    check(resetOutN == 1'b0 && resetOut == 1'b1 && wdFirePulse == 1'b0,
          "R11 reset state", int'(resetOutN), 0);
    rstN = 1'b1;
  endtask

  initial begin
    int n, f0;
    // Sweep hold and base counts: POR release, then watchdog cycling (R11, R3, R2)
    for (int h = 1; h <= 4; h++) begin
      for (int t = 2; t <= 5; t++) begin
        por(h, t);
        runLen(1'b0, 100, n); check(n == h, "R11 hold after block reset", n, h);
        f0 = fireSeen;
        runLen(1'b1, 100, n); check(n == t, "R3 released length", n, t);
        runLen(1'b0, 100, n); check(n == h, "R3 watchdog reset length", n, h);
        runLen(1'b1, 100, n); check(n == t, "R3 repeat released length", n, t);
        check(fireSeen - f0 == 2, "R12 one pulse per expiry", fireSeen - f0, 2);
      end
    end

    // Kick edges of both polarities (R4)
    por(2, 20);
    runLen(1'b0, 100, n);
    repeat (5) @(negedge clk);
    kick = 1'b1;
    runLen(1'b1, 100, n); check(n == 23, "R4 rising kick restart", n, 23);
    runLen(1'b0, 100, n);
    repeat (5) @(negedge clk);
    kick = 1'b0;
    runLen(1'b1, 100, n); check(n == 23, "R4 falling kick restart", n, 23);

    // Mode changes and extended timeout (R5, R6, R8, R7)
    por(2, 4);
    runLen(1'b0, 100, n);
    @(negedge clk);
    modeExt = 1'b1;
    runLen(1'b1, 5000, n); check(n == 2003, "R5 mode change to extended", n, 2003);
    runLen(1'b0, 100, n);
    runLen(1'b1, 5000, n); check(n == 2000, "R6 extended timeout", n, 2000);
    runLen(1'b0, 100, n);
    repeat (3) @(negedge clk);
    modeExt = 1'b0;
    runLen(1'b1, 5000, n); check(n == 7, "R5 mode change to normal", n, 7);
    kickDriven = 1'b0;
    runLen(1'b0, 100, n);
    runLen(1'b1, 100, n); check(n == 4, "R8 undriven kick ignored in normal mode", n, 4);
    runLen(1'b0, 100, n);
    @(negedge clk);
    modeExt = 1'b1;
    f0 = fireSeen;
    runLen(1'b1, 6000, n); check(n == 6000, "R7 self-kick keeps reset released", n, 6000);
    check(fireSeen == f0, "R7 no expiry pulse", fireSeen - f0, 0);

    // Watchdog disabled and supply-driven reset (R9, R1, R2, R12)
    modeExt = 1'b0; kickDriven = 1'b1; wdEnable = 1'b0;
    holdTicks = CNT_W'(5);
    repeat (4) @(negedge clk);
    runLen(1'b1, 100, n); check(n == 100, "R9 disabled watchdog never fires", n, 100);
    f0 = fireSeen;
    supplyLow = 1'b1;
    #1;
    check(resetOutN == 1'b0, "R1 immediate assert on supply low", int'(resetOutN), 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(resetOutN == 1'b0, "R1 held while supply low", int'(resetOutN), 0);
    end
    supplyLow = 1'b0;
    runLen(1'b0, 100, n); check(n == 5, "R2 hold after supply recovers", n, 5);
    check(fireSeen == f0, "R12 no pulse on supply reset", fireSeen - f0, 0);
    runLen(1'b1, 100, n); check(n == 100, "R9 release after supply reset", n, 100);

    check(invBad == 0, "R10 outputs complementary", invBad, 0);
    check(fireBad == 0, "R12 pulse coincides with reset", fireBad, 0);

    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule